// File: doc/BRIEF.md
# Polyphase Six-Tap Wavelet Analysis Filter Pair

This block performs one level of a one-dimensional wavelet analysis. A low-pass and a high-pass filter, each with six signed 16-bit taps, run side by side on the same input stream. The stream arrives two samples per cycle: an earlier sample and the sample right after it. For every pair accepted, the block emits one approximation coefficient and one detail coefficient, so the output is decimated by two. Results come out at full precision, three bits wider than a single product.

Each filter has three multiply-accumulate lanes that start new outputs in turn. The pair of taps a lane uses comes from a coefficient ring that advances by two taps with every accepted pair. Each incoming pair therefore adds to three outputs at once, one lane per tap pair. The lane that starts a new output overwrites its accumulator instead of adding to it. An output multiplexer picks the lane that has just taken its last tap pair.

When the final pair of a signal is marked, the block runs two more cycles with zero samples. These cycles finish the partial sums that are still open. The next signal may follow immediately afterwards.

Top module: `dwt6_filter_pair`

## Requirements
- R1: After synchronous reset, out_valid, out_approx and out_detail are zero and both coefficient sets are zero, so a signal sent before any load yields all-zero coefficients.
- R2: A cycle with coef_load high captures both coefficient buses. Tap k, k = 0..5, sits in bits [16k+15:16k] and weights the sample at offset k of an output's six-sample window. A load also abandons any signal in progress: nothing from it is ever emitted, and the next cycle has out_valid low.
- R3: For a signal of N = 2M samples s[0..N-1], with in_s0 = s[2p] and in_s1 = s[2p+1] for pair p, approximation x (x = 0..M-1) equals the sum over k = 0..5 of s[2x+k]·lo[k]. Samples past the end count as zero, so the last output is s[N-2]·lo[0] + s[N-1]·lo[1]. Results are exact and signed, DW+19 bits wide.
- R4: Detail output x follows the same formula with the high-pass taps, and it appears in the same cycle as approximation x.
- R5: When pairs arrive back to back, out_valid first rises in the cycle after the third pair is accepted. After that, one result pair is presented every cycle.
- R6: A cycle with in_valid low and no flush pending is a stall: no output is presented, and partial sums are held, so gaps inside a signal leave the results unchanged.
- R7: After the pair marked with in_last, two flush cycles follow, and every signal of M pairs yields exactly M results in order.
- R8: in_valid, in_last and the sample inputs are ignored during the two flush cycles.
- R9: Signals of one and two pairs yield one and two correctly padded results.
- R10: A new signal may start on the cycle right after the second flush cycle without mixing with the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coef_load | input | 1 | Capture both coefficient buses, abandon current signal |
| coef_lo | input | 96 | Low-pass taps, tap k at bits [16k+15:16k] |
| coef_hi | input | 96 | High-pass taps, same packing |
| in_valid | input | 1 | Sample pair present |
| in_last | input | 1 | Pair is the last of its signal |
| in_s0 | input | DW (12) | Earlier sample of the pair, signed |
| in_s1 | input | DW (12) | Later sample of the pair, signed |
| out_valid | output | 1 | Result pair present |
| out_approx | output | DW+19 (31) | Approximation coefficient, signed |
| out_detail | output | DW+19 (31) | Detail coefficient, signed |

## Verification
The hardest situation to reach from the ports is the end of a signal. There, the last two results are finished only by the zero-filled flush cycles, while a lane that opens during a flush must never report. Short signals of one and two pairs make this worst: almost every result is completed in a flush cycle. The stimulus table covers signal lengths of 1, 2, 3 and several longer values, with and without idle gaps. Directed runs add junk pairs sent during the flush, a second signal sent right after a flush, and a coefficient load in the middle of a signal, all to exercise this end-of-signal bookkeeping.

// File: rtl/dwt6_pkg.sv
package dwt6_pkg;

    localparam int NTAP      = 6;
    localparam int NLANE     = NTAP / 2;
    localparam int ACC_GUARD = 3;
    localparam int FLUSH_LEN = 2;

    typedef logic [1:0] lane_t;

    typedef struct packed {
        logic  step;
        logic  real_pair;
        lane_t start_lane;
        lane_t done_lane;
    } sched_t;

    function automatic lane_t next_lane(input lane_t p);
        return (p == lane_t'(NLANE - 1)) ? lane_t'(0) : p + lane_t'(1);
    endfunction

endpackage

// File: rtl/dwt6_mac_lane.sv
module dwt6_mac_lane #(
    parameter int DW = 12,
    parameter int CW = 16,
    parameter int AW = DW + CW + 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 clr,
    input  logic signed [DW-1:0] s0,
    input  logic signed [DW-1:0] s1,
    input  logic signed [CW-1:0] c0,
    input  logic signed [CW-1:0] c1,
    output logic signed [AW-1:0] sum
);
    localparam int PW = DW + CW;

    logic signed [PW-1:0] p0, p1;
    logic signed [AW-1:0] acc_q, pair_sum;

    assign p0       = PW'(s0) * PW'(c0);
    assign p1       = PW'(s1) * PW'(c1);
    assign pair_sum = AW'(p0) + AW'(p1);
    assign sum      = acc_q + pair_sum;

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else if (en)
            acc_q <= clr ? pair_sum : sum;
    end
endmodule

// File: rtl/dwt6_branch.sv
module dwt6_branch
    import dwt6_pkg::*;
#(
    parameter int DW = 12,
    parameter int CW = 16,
    parameter int AW = DW + CW + 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   coef_load,
    input  logic [NTAP*CW-1:0]     coef,
    input  logic signed [DW-1:0]   s0,
    input  logic signed [DW-1:0]   s1,
    input  sched_t                 sched,
    output logic signed [AW-1:0]   result
);
    logic signed [CW-1:0] ring [NLANE][2];
    logic signed [AW-1:0] lane_sum [NLANE];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < NLANE; j++) begin
                ring[j][0] <= '0;
                ring[j][1] <= '0;
            end
        end else if (coef_load) begin
            for (int j = 0; j < NLANE; j++) begin
                ring[j][0] <= coef[(2*j)*CW +: CW];
                ring[j][1] <= coef[(2*j+1)*CW +: CW];
            end
        end else if (sched.step) begin
            for (int j = 0; j < NLANE; j++) begin
                ring[j][0] <= ring[(j+1)%NLANE][0];
                ring[j][1] <= ring[(j+1)%NLANE][1];
            end
        end
    end

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        localparam int SL = (NLANE - l) % NLANE;
        dwt6_mac_lane #(.DW(DW), .CW(CW), .AW(AW)) u_lane (
            .clk (clk),
            .rst (rst),
            .en  (sched.step),
            .clr (sched.start_lane == lane_t'(l)),
            .s0  (s0),
            .s1  (s1),
            .c0  (ring[SL][0]),
            .c1  (ring[SL][1]),
            .sum (lane_sum[l])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            result <= '0;
        else if (sched.step)
            result <= lane_sum[sched.done_lane];
    end
endmodule

// File: rtl/dwt6_ctrl.sv
module dwt6_ctrl
    import dwt6_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       coef_load,
    input  logic       in_valid,
    input  logic       in_last,
    output sched_t     sched,
    output logic       emit,
    output logic [1:0] flush_cnt,
    output lane_t      phase
);
    logic [NLANE-1:0] live_q;
    logic             flushing;

    always_comb begin
        flushing         = (flush_cnt != 2'd0);
        sched.real_pair  = in_valid && !flushing && !coef_load;
        sched.step       = !coef_load && (in_valid || flushing);
        sched.start_lane = phase;
        sched.done_lane  = next_lane(phase);
        emit             = sched.step && live_q[sched.done_lane];
    end

    always_ff @(posedge clk) begin
        if (rst || coef_load) begin
            phase     <= '0;
            live_q    <= '0;
            flush_cnt <= '0;
        end else if (sched.step) begin
            phase                    <= next_lane(phase);
            live_q[sched.start_lane] <= sched.real_pair;
            live_q[sched.done_lane]  <= 1'b0;
            if (sched.real_pair && in_last)
                flush_cnt <= 2'(FLUSH_LEN);
            else if (flushing)
                flush_cnt <= flush_cnt - 2'd1;
        end
    end
endmodule

// File: rtl/dwt6_filter_pair.sv
module dwt6_filter_pair
    import dwt6_pkg::*;
#(
    parameter  int DW = 12,
    parameter  int CW = 16,
    localparam int AW = DW + CW + ACC_GUARD
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 coef_load,
    input  logic [NTAP*CW-1:0]   coef_lo,
    input  logic [NTAP*CW-1:0]   coef_hi,
    input  logic                 in_valid,
    input  logic                 in_last,
    input  logic signed [DW-1:0] in_s0,
    input  logic signed [DW-1:0] in_s1,
    output logic                 out_valid,
    output logic signed [AW-1:0] out_approx,
    output logic signed [AW-1:0] out_detail
);
    sched_t               sched;
    logic                 emit;
    logic [1:0]           flush_cnt;
    lane_t                phase;
    logic signed [DW-1:0] s0_eff, s1_eff;
    logic [NTAP*CW-1:0]   cbank [2];
    logic signed [AW-1:0] bres  [2];

    dwt6_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .coef_load (coef_load),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .sched     (sched),
        .emit      (emit),
        .flush_cnt (flush_cnt),
        .phase     (phase)
    );

    assign s0_eff   = sched.real_pair ? in_s0 : '0;
    assign s1_eff   = sched.real_pair ? in_s1 : '0;
    assign cbank[0] = coef_lo;
    assign cbank[1] = coef_hi;

    for (genvar b = 0; b < 2; b++) begin : g_branch
        dwt6_branch #(.DW(DW), .CW(CW), .AW(AW)) u_branch (
            .clk       (clk),
            .rst       (rst),
            .coef_load (coef_load),
            .coef      (cbank[b]),
            .s0        (s0_eff),
            .s1        (s1_eff),
            .sched     (sched),
            .result    (bres[b])
        );
    end

    assign out_approx = bres[0];
    assign out_detail = bres[1];

    always_ff @(posedge clk) begin
        if (rst)
            out_valid <= 1'b0;
        else
            out_valid <= emit;
    end
endmodule

// File: rtl/dwt6_chk.sv
module dwt6_chk (
    input logic       clk,
    input logic       rst,
    input logic       coef_load,
    input logic       in_valid,
    input logic       out_valid,
    input logic [1:0] flush_cnt,
    input logic [1:0] phase
);
    // R2: a load abandons the signal, nothing is presented next cycle
    a_r2_load_silences: assert property (@(posedge clk) disable iff (rst)
        coef_load |=> !out_valid);

    // R6: idle cycle outside a flush neither presents nor advances
    a_r6_stall_holds: assert property (@(posedge clk) disable iff (rst)
        (!coef_load && !in_valid && flush_cnt == 2'd0) |=> (!out_valid && $stable(phase)));

    // R7: flush never longer than two cycles and counts down
    a_r7_flush_bound: assert property (@(posedge clk) disable iff (rst)
        flush_cnt <= 2'd2);
    a_r7_flush_countdown: assert property (@(posedge clk) disable iff (rst)
        (!coef_load && flush_cnt == 2'd2) |=> (flush_cnt == 2'd1));

    // R5: a result only follows an accepted pair or a flush cycle
    a_r5_valid_cause: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid || flush_cnt != 2'd0));

    // R8: a flush cycle always advances the lane rotation, whatever in_valid is
    a_r8_flush_advances: assert property (@(posedge clk) disable iff (rst)
        (!coef_load && flush_cnt != 2'd0) |=>
        (phase == (($past(phase) == 2'd2) ? 2'd0 : $past(phase) + 2'd1)));

    a_r7_phase_range: assert property (@(posedge clk) disable iff (rst)
        phase != 2'd3);
endmodule

bind dwt6_filter_pair dwt6_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .coef_load (coef_load),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .flush_cnt (flush_cnt),
    .phase     (phase)
);

// File: tb/dwt6_filter_pair_tb.sv
module dwt6_filter_pair_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 12;
    localparam int CW = 16;
    localparam int AW = DW + CW + 3;
    localparam int NCASE = 7;
    localparam int CASE_M   [NCASE] = '{1, 2, 3, 7, 16, 33, 5};
    localparam bit CASE_GAP [NCASE] = '{0, 1, 0, 1, 0, 1, 1};
    localparam int CASE_SEED[NCASE] = '{11, 202, 3003, 47, 5150, 606, 77};

    logic clk = 0, rst = 1, coef_load = 0, in_valid = 0, in_last = 0;
    logic [6*CW-1:0] coef_lo = '0, coef_hi = '0;
    logic signed [DW-1:0] in_s0 = '0, in_s1 = '0;
    logic out_valid;
    logic signed [AW-1:0] out_approx, out_detail;

    int checks = 0, fails = 0;
    int unsigned st = 1;
    int lo_c[6], hi_c[6];
    int samp[256];
    longint exp_a[512], exp_d[512], got_a[512], got_d[512];
    int ne = 0, ng = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dwt6_filter_pair #(.DW(DW), .CW(CW)) u_dut (
        .clk(clk), .rst(rst), .coef_load(coef_load), .coef_lo(coef_lo), .coef_hi(coef_hi),
        .in_valid(in_valid), .in_last(in_last), .in_s0(in_s0), .in_s1(in_s1),
        .out_valid(out_valid), .out_approx(out_approx), .out_detail(out_detail));

    always @(negedge clk) begin
        if (out_valid && ng < 512) begin
            got_a[ng] = longint'(out_approx);
            got_d[ng] = longint'(out_detail);
            ng++;
        end
    end

    function automatic int unsigned nxt();
        st = st * 32'd1103515245 + 32'd12345;
        return st;
    endfunction
    function automatic int rsamp();
        int unsigned v = nxt();
        return int'((v >> 16) & 32'hFFF) - 2048;
    endfunction
    function automatic int rcoef();
        int unsigned v = nxt();
        return int'((v >> 8) & 32'hFFFF) - 32768;
    endfunction

    function automatic longint ref_out(int x, int m, bit hi);
        longint acc = 0;
        for (int k = 0; k < 6; k++) begin
            int idx = 2 * x + k;
            longint s = (idx < 2 * m) ? longint'(samp[idx]) : 0;
            acc += s * longint'(hi ? hi_c[k] : lo_c[k]);
        end
        return acc;
    endfunction

    task automatic chk(string tag, longint act, longint expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic load_coefs(int seed);
        st = seed;
        for (int k = 0; k < 6; k++) begin
            lo_c[k] = rcoef();
            hi_c[k] = rcoef();
            coef_lo[16*k +: 16] = 16'(lo_c[k]);
            coef_hi[16*k +: 16] = 16'(hi_c[k]);
        end
        coef_load = 1;
        @(negedge clk);
        coef_load = 0;
    endtask

    task automatic drive_pair(int a, int b, bit last);
        in_s0 = DW'(a); in_s1 = DW'(b); in_last = last; in_valid = 1;
        @(negedge clk);
        in_valid = 0; in_last = 0;
    endtask

    task automatic gen_signal(int m);
        for (int i = 0; i < 2 * m; i++) samp[i] = rsamp();
        for (int x = 0; x < m; x++) begin
            exp_a[ne] = ref_out(x, m, 0);
            exp_d[ne] = ref_out(x, m, 1);
            ne++;
        end
    endtask

    task automatic send_signal(int m, bit gap, bit junk);
        gen_signal(m);
        for (int p = 0; p < m; p++) begin
            drive_pair(samp[2*p], samp[2*p+1], p == m - 1);
            if (gap && (p % 2 == 1) && p != m - 1) @(negedge clk);
        end
        for (int f = 0; f < 2; f++) begin
            if (junk) begin
                in_s0 = DW'(rsamp()); in_s1 = DW'(rsamp()); in_last = 1; in_valid = 1;
            end
            @(negedge clk);
        end
        in_valid = 0; in_last = 0;
    endtask

    task automatic drain_check(string tag_n, string tag_a, string tag_d);
        repeat (4) @(negedge clk);
        chk(tag_n, ng, ne);
        for (int i = 0; i < ne && i < ng; i++) begin
            chk(tag_a, got_a[i], exp_a[i]);
            chk(tag_d, got_d[i], exp_d[i]);
        end
        ng = 0; ne = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 out_valid", longint'(out_valid), 0);
        chk("R1 out_approx", longint'(out_approx), 0);
        chk("R1 out_detail", longint'(out_detail), 0);
        for (int k = 0; k < 6; k++) begin lo_c[k] = 0; hi_c[k] = 0; end
        st = 99;
        send_signal(3, 0, 0);
        drain_check("R1 count", "R1 zero approx", "R1 zero detail");

        // table walk: R3/R4 values, R7 counts, R6 gaps, R9 short signals
        for (int i = 0; i < NCASE; i++) begin
            load_coefs(CASE_SEED[i]);
            chk("R2 no output after load", longint'(out_valid), 0);
            send_signal(CASE_M[i], CASE_GAP[i], 0);
            if (CASE_M[i] <= 2)
                drain_check("R9 R7 count", "R9 R3 approx", "R9 R4 detail");
            else if (CASE_GAP[i])
                drain_check("R6 R7 count", "R6 R3 approx", "R6 R4 detail");
            else
                drain_check("R7 count", "R3 approx", "R4 detail");
        end

        // R5 first-output latency with back-to-back pairs
        load_coefs(1234);
        gen_signal(4);
        drive_pair(samp[0], samp[1], 0);
        chk("R5 after pair 1", longint'(out_valid), 0);
        drive_pair(samp[2], samp[3], 0);
        chk("R5 after pair 2", longint'(out_valid), 0);
        drive_pair(samp[4], samp[5], 0);
        chk("R5 after pair 3", longint'(out_valid), 1);
        drive_pair(samp[6], samp[7], 1);
        chk("R5 after pair 4", longint'(out_valid), 1);
        @(negedge clk);
        chk("R7 flush 1 output", longint'(out_valid), 1);
        @(negedge clk);
        chk("R7 flush 2 output", longint'(out_valid), 1);
        @(negedge clk);
        chk("R7 quiet after flush", longint'(out_valid), 0);
        drain_check("R5 count", "R5 R3 approx", "R5 R4 detail");

        // R8 junk during flush
        load_coefs(4321);
        send_signal(5, 0, 1);
        drain_check("R8 count", "R8 approx", "R8 detail");

        // R10 back-to-back signals
        load_coefs(777);
        send_signal(4, 0, 0);
        send_signal(3, 1, 0);
        drain_check("R10 count", "R10 approx", "R10 detail");

        // R2 load mid-signal abandons it
        load_coefs(55);
        gen_signal(4);
        ne = 0;
        drive_pair(samp[0], samp[1], 0);
        drive_pair(samp[2], samp[3], 0);
        load_coefs(66);
        chk("R2 abort out_valid", longint'(out_valid), 0);
        repeat (3) @(negedge clk);
        chk("R2 abort emits nothing", ng, 0);
        ng = 0;
        send_signal(3, 0, 0);
        drain_check("R2 count", "R2 approx", "R2 detail");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule